// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write a clockless static RAM of 4096 words by 4 bits. The memory has active-low chip select and write enable strobes and one shared data bus. The host side is a simple handshake. The host holds a request with its address, write data and direction until the controller signals that it is ready, and the request is taken on that clock edge. A one-cycle completion pulse follows each access. For a read, the captured word comes with that pulse.

On the memory side the controller drives the address, both strobes, its own data output and an enable for that output. It takes the memory's data from a separate input, so the tristate buffer sits outside the block. Each memory timing minimum is a nanosecond parameter. It is turned into a clock-cycle count, rounded up, from the clock-period parameter.

For a write, write enable falls one cycle before chip select. Because of that order the memory never turns on its output drivers. The controller drives the bus only while both strobes are low. It keeps driving for one cycle after they rise, so the data has hold time. Between accesses there is always at least one cycle with chip select high and the controller's drivers off.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever idle, chip select and write enable are high (1), the data driver enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read holds chip select low with write enable high for exactly RD = ceil(T_RC_NS / CLK_NS) cycles. The address does not change during that window, and the word on `mem_dq_in` is captured at its last clock edge.
- R3: Every accepted request produces `rsp_valid` high for exactly one cycle. For a read, `rsp_rdata` in that cycle equals the word last written at that address, or the initial content if the address was never written.
- R4: For a write, write enable falls while chip select is still high, exactly one cycle before chip select falls.
- R5: During a write, both strobes stay low together for OV = max(ceil(T_WP_NS / CLK_NS), ceil(T_DW_NS / CLK_NS) + 1) cycles and then rise on the same clock edge.
- R6: The data driver enable rises only when both strobes have already been low for one cycle. It stays high for exactly one cycle after the strobes rise, and then goes low.
- R7: A request is accepted only while chip select is high and the drivers are off. Address and write data stay stable from acceptance until the access ends.
- R8: The data driver enable is never high while chip select is low and write enable is high.
- R9: Between two chip-select-low windows there is at least one cycle with chip select high and the drivers off. `req_ready` is high only in such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a request present is taken at this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last word read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the controller's data driver |
| mem_dq_in | input | DATA_W | Data bus as seen at the memory pins |

## Verification
The assertions check the strobe ordering on every cycle. They also check the strobe-window lengths and that the bus is never driven from both sides. They check address and data stability and the single-cycle completion pulse. What only the bench scenarios can show is the end-to-end effect: that the captured read data really meets the memory's access time, and that write data lands at the right address. They also show the nanosecond setup and width margins at the end of each write, and read-after-write ordering under random back-to-back traffic. A behavioural memory model in the bench measures these in real time.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_WSETUP,
    S_WLOW,
    S_WDRIVE,
    S_WREL
  } seq_state_t;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Strobe overlap: one undriven cycle, then enough driven cycles for data setup,
  // and never shorter than the write pulse minimum.
  function automatic int unsigned wr_overlap_cycles(input int unsigned wp_ns,
                                                    input int unsigned dw_ns,
                                                    input int unsigned clk_ns);
    int unsigned a;
    int unsigned b;
    a = ns_to_cycles(wp_ns, clk_ns);
    b = ns_to_cycles(dw_ns, clk_ns) + 1;
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq import sram_ctl_pkg::*; #(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned OV_CYC = 3,
  parameter int unsigned TW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          expired,
  output logic          timer_load,
  output logic [TW-1:0] timer_val,
  output logic          req_ready,
  output logic          accept,
  output logic          capture,
  output logic          done,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe
);
  localparam int unsigned LW = cnt_width(max2(RD_CYC, OV_CYC) + 1);

  seq_state_t state, nxt;
  logic wr_finish;

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_ready && req_valid;
  assign capture    = (state == S_READ) && expired;
  assign wr_finish  = (state == S_WDRIVE) && expired;
  assign timer_load = (accept && !req_we) || (state == S_WLOW);
  assign timer_val  = (state == S_WLOW) ? TW'(OV_CYC - 2) : TW'(RD_CYC - 1);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (accept) nxt = req_we ? S_WSETUP : S_READ;
      S_READ:   if (expired) nxt = S_IDLE;
      S_WSETUP: nxt = S_WLOW;
      S_WLOW:   nxt = S_WDRIVE;
      S_WDRIVE: if (expired) nxt = S_WREL;
      S_WREL:   nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  // Pin-level strobes are registered from the next state so they never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe   <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= nxt;
      mem_cs_n <= !(nxt == S_READ || nxt == S_WLOW || nxt == S_WDRIVE);
      mem_we_n <= !(nxt == S_WSETUP || nxt == S_WLOW || nxt == S_WDRIVE);
      mem_oe   <= (nxt == S_WDRIVE || nxt == S_WREL);
      done     <= capture || wr_finish;
    end
  end

  // Length of the current chip-select-low window, for the checks below.
  logic [LW-1:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_len <= '0;
    else if (mem_cs_n) low_len <= '0;
    else               low_len <= low_len + 1'b1;
  end

  // R2 R5
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> (low_len == ($past(mem_we_n) ? LW'(RD_CYC) : LW'(OV_CYC))));
  // R4
  we_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> mem_cs_n);
  // R4
  cs_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cs_n) && !mem_we_n) |-> $past(!mem_we_n && mem_cs_n));
  // R5
  strobes_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_cs_n) && $past(!mem_we_n)) |-> mem_we_n);
  // R6
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe) |-> (!mem_cs_n && !mem_we_n && $past(!mem_cs_n)));
  // R6
  oe_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe && mem_cs_n) |=> !mem_oe);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && !mem_oe));
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_cs_n,
  input  logic              mem_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_dq_in;
  end

  // R7
  accept_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (mem_cs_n && !mem_oe));
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe && $past(mem_oe)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));
  // R2
  capture_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !mem_cs_n);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl import sram_ctl_pkg::*; #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 4,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 25,
  parameter int unsigned T_WP_NS = 20,
  parameter int unsigned T_DW_NS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC = ns_to_cycles(T_RC_NS, CLK_NS);
  localparam int unsigned OV_CYC = wr_overlap_cycles(T_WP_NS, T_DW_NS, CLK_NS);
  localparam int unsigned TW     = cnt_width(max2(RD_CYC - 1, OV_CYC - 2));

  logic          timer_load;
  logic [TW-1:0] timer_val;
  logic          expired;
  logic          accept;
  logic          capture;

  sram_ctl_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (expired)
  );

  sram_ctl_seq #(.RD_CYC(RD_CYC), .OV_CYC(OV_CYC), .TW(TW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .expired    (expired),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture    (capture),
    .done       (rsp_valid),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe     (mem_dq_oe)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .mem_cs_n   (mem_cs_n),
    .mem_oe     (mem_dq_oe),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_cs_n && mem_we_n));
  // R3
  done_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_cs_n) && mem_cs_n));
endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 4;
  localparam int unsigned CLKP = 8;
  localparam real T_RC = 25.0;
  localparam real T_WP = 20.0;
  localparam real T_DS = 12.0;
  localparam real T_AW = 20.0;

  function automatic int b_ceil(input int t, input int p);
    return (t % p == 0) ? t / p : t / p + 1;
  endfunction
  function automatic int exp_rd();
    return b_ceil(25, CLKP);
  endfunction
  function automatic int exp_ov();
    int a;
    int b;
    a = b_ceil(20, CLKP);
    b = b_ceil(12, CLKP) + 1;
    return (a > b) ? a : b;
  endfunction
  function automatic logic [DW-1:0] init_word(input int a);
    return DW'((a & 15) ^ ((a >> 4) & 15) ^ ((a >> 8) & 15) ^ 5);
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] bus;

  always #(CLKP/2) clk = ~clk;

  sram_ctl #(.CLK_NS(CLKP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(bus)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit started = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] sram [1 << AW];
  logic [DW-1:0] shadow [1 << AW];
  realtime t_rchange = 0.0, t_data = 0.0, t_addr = 0.0, t_wstart = 0.0, rv_stamp = -1.0;
  logic rv = 1'b0;
  logic mdrive, mvalid, wr_act;
  bit in_wr = 0;

  always_comb mdrive = !mem_cs_n && mem_we_n;
  always_comb wr_act = !mem_cs_n && !mem_we_n;
  always @(mem_cs_n or mem_we_n or mem_addr) t_rchange = $realtime;
  always @(mem_dq_out or mem_dq_oe) t_data = $realtime;
  always @(mem_addr) t_addr = $realtime;
  always @(negedge clk) begin
    rv       <= ($realtime - t_rchange) >= T_RC;
    rv_stamp <= t_rchange;
  end
  always_comb mvalid = rv && (rv_stamp == t_rchange);
  always_comb begin
    if (mem_dq_oe)   bus = mem_dq_out;
    else if (mdrive) bus = mvalid ? sram[mem_addr] : ~sram[mem_addr];
    else             bus = '0;
  end

  always @(wr_act) begin
    if (started) begin
      if (wr_act) begin
        t_wstart = $realtime;
        in_wr = 1;
      end else if (in_wr) begin
        in_wr = 0;
        check(($realtime - t_wstart) >= T_WP, "R5 strobe width ns",
              int'($realtime - t_wstart), int'(T_WP));
        check(mem_dq_oe == 1'b1, "R6 driving at write end", int'(mem_dq_oe), 1);
        check(($realtime - t_data) >= T_DS, "R6 data setup ns",
              int'($realtime - t_data), int'(T_DS));
        check(($realtime - t_addr) >= T_AW, "R7 address setup ns",
              int'($realtime - t_addr), int'(T_AW));
        sram[mem_addr] = mem_dq_out;
      end
    end
  end

  // ---------------- pin-level monitor ----------------
  bit prev_cs = 1, prev_we = 1, prev_oe = 0, prev_rsp = 0, win_read = 1, clash = 0;
  int low_run = 0, pre_we = 0, oe_tail = 0, gap = 1;

  always @(negedge clk) begin
    if (started) begin
      if (mem_dq_oe && !mem_cs_n && mem_we_n && !clash) begin
        clash = 1;
        $display("FAIL R8: bus driven from both sides at %0t", $time);
        n_fail++;
      end
      if (!mem_cs_n) begin
        if (prev_cs) begin
          check(gap >= 1, "R9 idle gap", gap, 1);
          if (!mem_we_n) check(pre_we == 1, "R4 write enable lead", pre_we, 1);
          win_read = mem_we_n;
          low_run = 1;
          gap = 0;
          pre_we = 0;
        end else low_run++;
      end else begin
        if (!prev_cs) begin
          if (win_read) check(low_run == exp_rd(), "R2 read window", low_run, exp_rd());
          else begin
            check(low_run == exp_ov(), "R5 overlap cycles", low_run, exp_ov());
            check(mem_we_n == 1'b1, "R5 strobes rise together", int'(mem_we_n), 1);
          end
        end
        if (!mem_dq_oe) gap++;
        pre_we = mem_we_n ? 0 : pre_we + 1;
      end
      if (mem_dq_oe && !prev_oe)
        check(!mem_cs_n && !mem_we_n && !prev_cs, "R6 driver start", int'(mem_cs_n), 0);
      if (mem_dq_oe && mem_cs_n) oe_tail++;
      if (!mem_dq_oe && prev_oe) begin
        check(oe_tail == 1, "R6 driver tail", oe_tail, 1);
        oe_tail = 0;
      end
      if (prev_rsp) check(rsp_valid == 1'b0, "R3 pulse width", int'(rsp_valid), 0);
      if (req_ready) check(mem_cs_n && !mem_dq_oe, "R9 ready only when quiet", int'(mem_cs_n), 1);
      prev_cs = mem_cs_n; prev_we = mem_we_n; prev_oe = mem_dq_oe; prev_rsp = rsp_valid;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a;
    req_wdata = ~d;
    while (!rsp_valid) @(negedge clk);
    if (w) shadow[a] = d;
    else check(rsp_rdata == shadow[a], "R3 read data", int'(rsp_rdata), int'(shadow[a]));
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        report();
      end
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < (1 << AW); i++) begin
      sram[i] = init_word(i);
      shadow[i] = init_word(i);
    end
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1 during reset
    check(mem_cs_n == 1'b1, "R1 cs in reset", int'(mem_cs_n), 1);
    check(mem_we_n == 1'b1, "R1 we in reset", int'(mem_we_n), 1);
    check(mem_dq_oe == 1'b0, "R1 oe in reset", int'(mem_dq_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1;
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
    repeat (2) @(negedge clk);
    // directed corners: untouched read, extreme addresses, overwrite, back-to-back
    run_op(0, 12'h123, 4'h0);
    run_op(1, 12'h000, 4'hF);
    run_op(1, 12'hFFF, 4'h0);
    run_op(0, 12'h000, 4'h0);
    run_op(0, 12'hFFF, 4'h0);
    run_op(1, 12'h5A5, 4'h3);
    run_op(1, 12'h5A5, 4'hC);
    run_op(0, 12'h5A5, 4'h0);
    run_op(0, 12'h5A5, 4'h0);
    repeat (3) @(negedge clk);
    // R1 idle again
    check(mem_cs_n && mem_we_n && !mem_dq_oe && req_ready, "R1 idle state",
          int'(mem_cs_n), 1);
    // random mix over a small pool of addresses at both ends
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      a = AW'(($urandom & 32'hF) | ((($urandom & 1) != 0) ? 32'hFF0 : 32'h0));
      run_op(1'($urandom & 1), a, DW'($urandom));
    end
    check(clash == 0, "R8 no contention seen", int'(clash), 0);
    report();
  end
endmodule